// File: doc/BRIEF.md
# Job Request Header Parser

This block sits on a byte stream that carries job requests from a network-facing controller toward an application. Each request starts with a fixed eight-byte header. The parser captures the header, decodes the request kind, keeps the request's job tag so that a response can be matched to it, and then passes exactly the announced number of payload bytes to a valid/ready output. The first and last payload bytes carry markers. When the payload is done, the parser waits for the next header.

The parser has two states. `ST_HEADER` collects header bytes and always accepts input. `ST_PAYLOAD` forwards bytes and passes the downstream ready signal back to the source. The transitions are:
- `ST_HEADER` to `ST_PAYLOAD` when the eighth header byte is accepted and the length is nonzero.
- `ST_HEADER` back to `ST_HEADER` when the eighth header byte carries a zero length.
- `ST_PAYLOAD` to `ST_HEADER` when the final payload byte is handed over.
- Any state to `ST_HEADER` on synchronous reset.

After each complete header, exactly one of four decode pulses fires: status, configure, reboot or application function. The type code and job tag are held on ports until the next header completes.

Top module: `job_hdr_parser`

## Requirements
- R1: Header byte positions, counted from 0 in arrival order: byte 0 is the type code, byte 1 is the job tag, and bytes 4 to 7 are the payload length in bytes, sent most significant byte first.
- R2: Type code 0x00 raises `pulse_status` for exactly one cycle, in the cycle after the eighth header byte is accepted. No other pulse is raised in that cycle.
- R3: Type code 0x01 raises `pulse_config` in the same way. Pulses are never raised in two consecutive cycles.
- R4: Type code 0xFF raises `pulse_reboot` in the same way.
- R5: Type codes 0x02 to 0xFE raise `pulse_user`, and `req_type` carries the code during that pulse.
- R6: `job_tag` and `req_type` take the values from the header in the pulse cycle. They stay unchanged until the next header completes, including while a later header is only partly received.
- R7: Exactly the announced number of payload bytes are forwarded unchanged. `out_first` is set on the first of them and `out_last` on the final one. After the final handshake, the parser returns to `ST_HEADER`.
- R8: A zero-length request still produces its decode pulse and forwards no payload. The byte that follows it is taken as the type byte of a new header.
- R9: Header bytes 2 and 3 have no effect on the decode, the tag or the payload.
- R10: In `ST_HEADER`, `in_ready` is 1 and `out_valid` is 0. In `ST_PAYLOAD`, `in_ready` equals `out_ready` and `out_valid` equals `in_valid`.
- R11: Synchronous reset returns the parser to `ST_HEADER` with the header and payload counters cleared, the pulses low, and `job_tag` and `req_type` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Incoming request byte |
| in_valid | input | 1 | Incoming byte is present |
| in_ready | output | 1 | Parser takes the byte this cycle |
| out_data | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | Payload byte is present |
| out_ready | input | 1 | Consumer takes the payload byte |
| out_first | output | 1 | Marks the first payload byte |
| out_last | output | 1 | Marks the final payload byte |
| pulse_status | output | 1 | Status request decoded |
| pulse_config | output | 1 | Configuration request decoded |
| pulse_reboot | output | 1 | Reboot request decoded |
| pulse_user | output | 1 | Application function request decoded |
| req_type | output | 8 | Type code of the latest request |
| job_tag | output | 8 | Job tag of the latest request |

## Verification
The decode pulse of a request and the handover of its first payload byte can occur in the same cycle. The bench provokes this by presenting the first payload byte directly after the eighth header byte. Its negative-edge monitor records whether a pulse and a payload handshake were seen together. The check is judged on three things: that coincidence, the identity of the pulse, and the data and first marker of that byte. A second same-cycle case is a zero-length request's pulse together with acceptance of the next request's type byte. The bench sends two requests back to back with no idle cycle and expects both to decode.

// File: rtl/jhp_pkg.sv
package jhp_pkg;

    typedef enum logic {
        ST_HEADER  = 1'b0,
        ST_PAYLOAD = 1'b1
    } jhp_state_e;

    localparam logic [7:0] CODE_STATUS = 8'h00;
    localparam logic [7:0] CODE_CONFIG = 8'h01;
    localparam logic [7:0] CODE_REBOOT = 8'hFF;

    // One bit per request kind; at most one set after a decode.
    typedef struct packed {
        logic status;
        logic config_req;
        logic reboot;
        logic user;
    } jhp_kind_t;

endpackage

// File: rtl/jhp_hdr_capture.sv
module jhp_hdr_capture #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic [7:0]       byte_in,
    output logic             hdr_done,
    output logic [7:0]       type_q,
    output logic [7:0]       tag_q,
    output logic [LEN_W-1:0] len_full
);
    localparam int LEN_BYTES = LEN_W / 8;
    localparam int HDR_BYTES = 4 + LEN_BYTES;
    localparam int IDX_W     = $clog2(HDR_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] TYPE_IDX  = IDX_W'(0);
    localparam logic [IDX_W-1:0] TAG_IDX   = IDX_W'(1);
    localparam logic [IDX_W-1:0] FIRST_LEN = IDX_W'(4);

    logic [IDX_W-1:0]  idx_q;
    // Holds all length bytes except the one arriving with the final beat.
    logic [LEN_W-9:0]  len_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (beat) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= '0;
            tag_q  <= '0;
            len_sh <= '0;
        end else if (beat) begin
            if (idx_q == TYPE_IDX) type_q <= byte_in;
            if (idx_q == TAG_IDX)  tag_q  <= byte_in;
            // Bytes 2 and 3 fall through untouched.
            if (idx_q >= FIRST_LEN) begin
                if (LEN_W > 16) begin
                    len_sh <= {len_sh[LEN_W-17:0], byte_in};
                end else begin
                    len_sh <= byte_in[LEN_W-9:0];
                end
            end
        end
    end

    assign hdr_done = beat && (idx_q == LAST_IDX);
    assign len_full = {len_sh, byte_in};

endmodule

// File: rtl/jhp_type_decode.sv
module jhp_type_decode
    import jhp_pkg::*;
(
    input  logic [7:0] code,
    output jhp_kind_t  kind
);
    always_comb begin
        kind = '0;
        unique case (code)
            CODE_STATUS: kind.status     = 1'b1;
            CODE_CONFIG: kind.config_req = 1'b1;
            CODE_REBOOT: kind.reboot     = 1'b1;
            default:     kind.user       = 1'b1;
        endcase
    end

endmodule

// File: rtl/jhp_payload_ctr.sv
module jhp_payload_ctr #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             beat,
    output logic             is_first,
    output logic             is_last
);
    logic [LEN_W-1:0] remain_q;
    logic             first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            first_q  <= 1'b0;
        end else if (load) begin
            remain_q <= load_len;
            first_q  <= 1'b1;
        end else if (beat) begin
            remain_q <= remain_q - 1'b1;
            first_q  <= 1'b0;
        end
    end

    assign is_first = first_q;
    assign is_last  = (remain_q == LEN_W'(1));

endmodule

// File: rtl/job_hdr_parser.sv
module job_hdr_parser
    import jhp_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_first,
    output logic       out_last,
    output logic       pulse_status,
    output logic       pulse_config,
    output logic       pulse_reboot,
    output logic       pulse_user,
    output logic [7:0] req_type,
    output logic [7:0] job_tag
);
    jhp_state_e       state_q, state_d;
    logic             hdr_beat, pay_beat, hdr_done;
    logic [7:0]       type_cap, tag_cap;
    logic [LEN_W-1:0] len_full;
    logic             len_nonzero;
    logic             pay_first, pay_last;
    jhp_kind_t        kind_dec, kind_q;

    assign hdr_beat    = (state_q == ST_HEADER) && in_valid;
    assign pay_beat    = (state_q == ST_PAYLOAD) && in_valid && out_ready;
    assign len_nonzero = (len_full != '0);

    jhp_hdr_capture #(.LEN_W(LEN_W)) u_hdr (
        .clk      (clk),
        .rst      (rst),
        .beat     (hdr_beat),
        .byte_in  (in_data),
        .hdr_done (hdr_done),
        .type_q   (type_cap),
        .tag_q    (tag_cap),
        .len_full (len_full)
    );

    jhp_type_decode u_dec (
        .code (type_cap),
        .kind (kind_dec)
    );

    jhp_payload_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (hdr_done && len_nonzero),
        .load_len (len_full),
        .beat     (pay_beat),
        .is_first (pay_first),
        .is_last  (pay_last)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HEADER:  if (hdr_done && len_nonzero) state_d = ST_PAYLOAD;
            ST_PAYLOAD: if (pay_beat && pay_last)    state_d = ST_HEADER;
            default:    state_d = ST_HEADER;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HEADER;
        else     state_q <= state_d;
    end

    // Decode pulses and held request identity.
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= '0;
            req_type <= '0;
            job_tag  <= '0;
        end else if (hdr_done) begin
            kind_q   <= kind_dec;
            req_type <= type_cap;
            job_tag  <= tag_cap;
        end else begin
            kind_q   <= '0;
        end
    end

    // Stream-side outputs per state.
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        out_data  = '0;
        out_first = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_HEADER: begin
                in_ready  = 1'b1;
            end
            ST_PAYLOAD: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_first = in_valid && pay_first;
                out_last  = in_valid && pay_last;
            end
            default: in_ready = 1'b1;
        endcase
    end

    assign pulse_status = kind_q.status;
    assign pulse_config = kind_q.config_req;
    assign pulse_reboot = kind_q.reboot;
    assign pulse_user   = kind_q.user;

endmodule

// File: rtl/jhp_checker.sv
module jhp_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_last,
    input logic       pulse_status,
    input logic       pulse_config,
    input logic       pulse_reboot,
    input logic       pulse_user,
    input logic [7:0] req_type,
    input logic [7:0] job_tag
);
    logic any_pulse;
    assign any_pulse = pulse_status | pulse_config | pulse_reboot | pulse_user;

    assert_one_kind_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pulse_status, pulse_config, pulse_reboot, pulse_user}));

    assert_pulse_isolated_R3: assert property (@(posedge clk) disable iff (rst)
        any_pulse |=> !any_pulse);

    assert_config_code_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_config |-> (req_type == 8'h01));

    assert_reboot_code_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_reboot |-> (req_type == 8'hFF));

    assert_user_range_R5: assert property (@(posedge clk) disable iff (rst)
        pulse_user |-> (req_type != 8'h00 && req_type != 8'h01 && req_type != 8'hFF));

    assert_tag_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !any_pulse |-> ($stable(job_tag) && $stable(req_type)));

    assert_last_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    assert_ready_pass_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_valid && (in_ready == out_ready)));

endmodule

bind job_hdr_parser jhp_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_last     (out_last),
    .pulse_status (pulse_status),
    .pulse_config (pulse_config),
    .pulse_reboot (pulse_reboot),
    .pulse_user   (pulse_user),
    .req_type     (req_type),
    .job_tag      (job_tag)
);

// File: tb/job_hdr_parser_tb.sv
`timescale 1ns/1ps
module job_hdr_parser_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       out_first, out_last;
    logic       pulse_status, pulse_config, pulse_reboot, pulse_user;
    logic [7:0] req_type, job_tag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit bp_mode  = 1'b0;
    bit hdr_phase = 1'b0;

    // Monitor records
    int         pulse_cnt;
    logic [3:0] pulse_vec;
    logic [7:0] seen_type, seen_tag;
    bit         coincide;
    int         cap_cnt;
    int         hdr_viol;
    logic [7:0] cap_data  [0:511];
    bit         cap_first [0:511];
    bit         cap_last  [0:511];

    always #2.5 clk = ~clk;

    job_hdr_parser u_dut (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_first(out_first), .out_last(out_last),
        .pulse_status(pulse_status), .pulse_config(pulse_config),
        .pulse_reboot(pulse_reboot), .pulse_user(pulse_user),
        .req_type(req_type), .job_tag(job_tag)
    );

    always begin
        @(posedge clk);
        #1;
        out_ready = bp_mode ? ~out_ready : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_status | pulse_config | pulse_reboot | pulse_user) begin
                pulse_cnt++;
                pulse_vec = {pulse_status, pulse_config, pulse_reboot, pulse_user};
                seen_type = req_type;
                seen_tag  = job_tag;
                if (out_valid && out_ready) coincide = 1'b1;
            end
            if (out_valid && out_ready && cap_cnt < 512) begin
                cap_data[cap_cnt]  = out_data;
                cap_first[cap_cnt] = out_first;
                cap_last[cap_cnt]  = out_last;
                cap_cnt++;
            end
            if (hdr_phase && out_valid) hdr_viol++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        pulse_cnt = 0; pulse_vec = '0; seen_type = '0; seen_tag = '0;
        coincide = 1'b0; cap_cnt = 0; hdr_viol = 0;
    endtask

    function automatic logic [7:0] pay_byte(input logic [7:0] id, input int k);
        return 8'((id * 7) + (k * 13));
    endfunction

    // Called at posedge+1; returns at posedge+1 after the byte is taken.
    task automatic push(input logic [7:0] b);
        bit ok;
        in_valid = 1'b1;
        in_data  = b;
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
            #1;
        end while (!ok);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send(input logic [7:0] ty, input logic [7:0] id,
                        input logic [7:0] u2, input logic [7:0] u3, input int len);
        logic [31:0] l;
        l = 32'(len);
        hdr_phase = 1'b1;
        push(ty); push(id); push(u2); push(u3);
        push(l[31:24]); push(l[23:16]); push(l[15:8]); push(l[7:0]);
        hdr_phase = 1'b0;
        for (int k = 0; k < len; k++) push(pay_byte(id, k));
    endtask

    task automatic verify(input string req, input logic [7:0] ty, input logic [7:0] id,
                          input int len, input logic [3:0] vec);
        int bad;
        chk(pulse_cnt == 1, {req, " pulse count"}, pulse_cnt, 1);
        chk(pulse_vec == vec, {req, " pulse kind"}, pulse_vec, vec);
        chk(seen_type == ty, {req, " req_type"}, seen_type, ty);
        chk(seen_tag == id && job_tag == id, "R6 job_tag", job_tag, id);
        chk(cap_cnt == len, "R7 payload count", cap_cnt, len);
        bad = 0;
        for (int k = 0; k < cap_cnt && k < len; k++) begin
            if (cap_data[k] != pay_byte(id, k)) bad++;
            if (cap_first[k] != (k == 0)) bad++;
            if (cap_last[k] != (k == len - 1)) bad++;
        end
        chk(bad == 0, "R7 payload data/markers", bad, 0);
        chk(hdr_viol == 0, "R10 no output in header", hdr_viol, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        chk({pulse_status, pulse_config, pulse_reboot, pulse_user} == 4'b0,
            "R11 pulses", {pulse_status, pulse_config, pulse_reboot, pulse_user}, 0);
        chk(job_tag == 8'h00 && req_type == 8'h00, "R11 tag/type", {job_tag, req_type}, 0);
    endtask

    task automatic t_status();
        clear_mon();
        send(8'h00, 8'h11, 8'h00, 8'h00, 3);
        idle(3);
        verify("R2 status", 8'h00, 8'h11, 3, 4'b1000);
    endtask

    task automatic t_config_backpressure();
        clear_mon();
        bp_mode = 1'b1;
        send(8'h01, 8'h22, 8'h00, 8'h00, 5);
        idle(3);
        bp_mode = 1'b0;
        verify("R3 config with R10 backpressure", 8'h01, 8'h22, 5, 4'b0100);
    endtask

    task automatic t_reboot_zero();
        clear_mon();
        send(8'hFF, 8'h33, 8'h00, 8'h00, 0);
        idle(3);
        verify("R4 R8 reboot zero-length", 8'hFF, 8'h33, 0, 4'b0010);
    endtask

    task automatic t_zero_back_to_back();
        clear_mon();
        send(8'h80, 8'h41, 8'h00, 8'h00, 0);
        send(8'h00, 8'h42, 8'h00, 8'h00, 2);
        idle(3);
        chk(pulse_cnt == 2, "R8 two decodes back to back", pulse_cnt, 2);
        chk(pulse_vec == 4'b1000 && seen_tag == 8'h42, "R8 next header decoded",
            {pulse_vec, seen_tag}, {4'b1000, 8'h42});
        chk(cap_cnt == 2 && cap_data[0] == pay_byte(8'h42, 0), "R8 payload after zero-length",
            cap_cnt, 2);
    endtask

    task automatic t_user_codes();
        clear_mon();
        send(8'h02, 8'h50, 8'hFF, 8'h01, 1);
        idle(3);
        verify("R5 R9 user 0x02", 8'h02, 8'h50, 1, 4'b0001);
        clear_mon();
        send(8'hFE, 8'h51, 8'hA5, 8'h5A, 4);
        idle(3);
        verify("R5 R9 user 0xFE", 8'hFE, 8'h51, 4, 4'b0001);
        clear_mon();
        send(8'h80, 8'h52, 8'h00, 8'hFF, 2);
        idle(3);
        verify("R5 user 0x80", 8'h80, 8'h52, 2, 4'b0001);
    endtask

    task automatic t_big_endian();
        clear_mon();
        send(8'h10, 8'h55, 8'h00, 8'h00, 258);
        idle(3);
        verify("R1 length 0x102 msb first", 8'h10, 8'h55, 258, 4'b0001);
    endtask

    task automatic t_coincide();
        clear_mon();
        send(8'h03, 8'h66, 8'h00, 8'h00, 3);
        idle(3);
        chk(coincide, "R7 pulse with first payload handshake", coincide, 1);
        verify("R5 coincide request", 8'h03, 8'h66, 3, 4'b0001);
    endtask

    task automatic t_hold_and_reset();
        clear_mon();
        send(8'h04, 8'h77, 8'h00, 8'h00, 1);
        idle(2);
        clear_mon();
        hdr_phase = 1'b1;
        push(8'h01); push(8'h99); push(8'h00); push(8'h00);
        idle(2);
        hdr_phase = 1'b0;
        chk(job_tag == 8'h77 && req_type == 8'h04, "R6 hold during partial header",
            {job_tag, req_type}, {8'h77, 8'h04});
        chk(pulse_cnt == 0, "R6 no pulse on partial header", pulse_cnt, 0);
        do_reset();
        t_reset_state();
        clear_mon();
        send(8'h00, 8'hAB, 8'h00, 8'h00, 2);
        idle(3);
        verify("R11 parse after mid-header reset", 8'h00, 8'hAB, 2, 4'b1000);
    endtask

    initial begin
        clear_mon();
        do_reset();
        t_reset_state();
        t_status();
        t_config_backpressure();
        t_reboot_zero();
        t_zero_back_to_back();
        t_user_codes();
        t_big_endian();
        t_coincide();
        t_hold_and_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule